// File: doc/BRIEF.md
# Disk Controller Status Register Pair

This block gives a host two read-only status registers for a floppy-style disk controller. The first register sits at offset 0 and shows the track-zero input, a latched record of the head-step output, the DMA request and the pending interrupt. The second register sits at offset 1 and shows the two motor enables, the write gate, drive select 0, and two toggle bits. Each toggle bit flips on every inactive (falling) edge of the read-data or write-data strobe. The registered values drive an 8-bit read bus. An output enable tells the surrounding bus logic when to drive it.

There are two reset domains. The hardware reset is asynchronous and active low, and it clears every stored bit. The software reset is a synchronous level. While it is high it holds the step latch, the toggle bits and the write-gate copy at zero. The motor-enable and drive-select copies keep tracking their inputs during a software reset. A mode input picks the PS/2 layout, where both registers are readable, or the PC/AT layout, where the second register never drives the bus.

Top module: `disk_status_regs`

## Requirements
- R1: During and after hardware reset (hwRstN low), with all inputs low, offset 0 reads 8'h00 and offset 1 reads 8'hC0.
- R2: Offset 0 bit 4 shows trackZero, bit 6 shows dmaReq and bit 7 shows irqPending. Each is sampled on one clock edge and is visible after the next rising edge. Bits 3:0 read 0.
- R3: Offset 0 bit 5 is set one clock after a rising edge of stepOut. It stays 1 after stepOut falls and is not cleared by reads of the register.
- R4: A dirRead pulse clears offset 0 bit 5 at the next edge. If a stepOut rising edge falls in the same cycle, the bit stays 1.
- R5: Offset 0 bit 5 is cleared by the software reset and by the hardware reset.
- R6: Offset 1 bits 1:0 show motorEn[1:0], bit 2 shows writeGate and bit 5 shows driveSel0, one clock after sampling. Bits 7:6 always read 1.
- R7: While swReset is high, offset 1 bits 1:0 and bit 5 keep tracking motorEn and driveSel0.
- R8: Offset 1 bit 3 flips on each falling edge of rdStrobe. The change is visible three rising clock edges after the input changes, because of the two synchronizer stages. Rising edges have no effect.
- R9: Offset 1 bit 4 behaves the same way for wrStrobe.
- R10: While swReset is high, offset 1 bits 4:2 read 0. A hardware reset also clears them.
- R11: busOe is 1 only when hostRd is high and hostAddr is 0, or hostAddr is 1 with ps2Mode high. When busOe is 0, busData is 0.
- R12: With ps2Mode low, a read of offset 1 gives busOe 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hwRstN | input | 1 | Asynchronous hardware reset, active low |
| swReset | input | 1 | Synchronous software reset level |
| ps2Mode | input | 1 | 1: PS/2 layout, 0: PC/AT layout |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | ADDR_W | Register offset |
| dirRead | input | 1 | Pulse marking a read of the direction register |
| trackZero | input | 1 | Track-zero input |
| stepOut | input | 1 | Head step output, active high |
| dmaReq | input | 1 | DMA request output |
| irqPending | input | 1 | Interrupt output state |
| motorEn | input | 2 | Motor enable outputs |
| writeGate | input | 1 | Write gate output |
| driveSel0 | input | 1 | Drive select 0 from the output control register |
| rdStrobe | input | 1 | Asynchronous read-data strobe |
| wrStrobe | input | 1 | Asynchronous write-data strobe |
| busData | output | 8 | Read data |
| busOe | output | 1 | Read bus drive enable |

## Verification
The assertions check on every cycle that a step rising edge latches, that a dirRead without a coincident rise clears the latch, that the software reset clears the soft-domain bits while the motor and drive-select copies keep tracking, and that the fixed bits and the PC/AT output-enable rule hold. Only the bench's scenarios can show the toggle parity over long edge sequences through the synchronizer latency. The same is true of the full address and mode decode sweep, the level mapping over all input combinations, and the recovery after an asynchronous hardware reset.

// File: rtl/disk_status_pkg.sv
package disk_status_pkg;
  localparam int OFFSET_A = 0;
  localparam int OFFSET_B = 1;
  localparam int DATA_W   = 8;

  typedef struct packed {
    logic clrSoft;
    logic stepSet;
    logic stepClr;
    logic rdFlip;
    logic wrFlip;
    logic selA;
    logic selB;
  } strobe_t;
endpackage

// File: rtl/disk_status_ctrl.sv
module disk_status_ctrl
  import disk_status_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              hwRstN,
  input  logic              swReset,
  input  logic              ps2Mode,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              dirRead,
  input  logic              stepOut,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  output strobe_t           strb,
  output logic              busOe
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] rdChain;
  logic [CHAIN-1:0] wrChain;
  logic             stepPrev;
  logic             hitA;
  logic             hitB;

  // synchronizer stages plus one history stage for edge detection
  generate
    for (genvar g = 0; g < CHAIN; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge hwRstN) begin
          if (!hwRstN) begin
            rdChain[0] <= 1'b0;
            wrChain[0] <= 1'b0;
          end else begin
            rdChain[0] <= rdStrobe;
            wrChain[0] <= wrStrobe;
          end
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge hwRstN) begin
          if (!hwRstN) begin
            rdChain[g] <= 1'b0;
            wrChain[g] <= 1'b0;
          end else begin
            rdChain[g] <= rdChain[g-1];
            wrChain[g] <= wrChain[g-1];
          end
        end
      end
    end
  endgenerate

  // step is a synchronous output of the controller; history kept through reset
  always_ff @(posedge clk) begin
    stepPrev <= stepOut;
  end

  assign hitA = (hostAddr == ADDR_W'(OFFSET_A));
  assign hitB = (hostAddr == ADDR_W'(OFFSET_B)) && ps2Mode;

  always_comb begin
    strb.clrSoft = swReset;
    strb.stepSet = stepOut && !stepPrev;
    strb.stepClr = dirRead;
    strb.rdFlip  = !rdChain[CHAIN-2] && rdChain[CHAIN-1];
    strb.wrFlip  = !wrChain[CHAIN-2] && wrChain[CHAIN-1];
    strb.selA    = hostRd && hitA;
    strb.selB    = hostRd && hitB;
  end

  assign busOe = strb.selA || strb.selB;
endmodule

// File: rtl/disk_status_dpath.sv
module disk_status_dpath
  import disk_status_pkg::*;
(
  input  logic              clk,
  input  logic              hwRstN,
  input  strobe_t           strb,
  input  logic              trackZero,
  input  logic              dmaReq,
  input  logic              irqPending,
  input  logic [1:0]        motorEn,
  input  logic              writeGate,
  input  logic              driveSel0,
  output logic [DATA_W-1:0] statA,
  output logic [DATA_W-1:0] statB,
  output logic [DATA_W-1:0] busData
);
  logic       trkQ, dmaQ, irqQ, drvQ, wgQ;
  logic [1:0] motorQ;
  logic       stepLatch, tglRd, tglWr;

  // hardware-reset-only domain
  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      trkQ   <= 1'b0;
      dmaQ   <= 1'b0;
      irqQ   <= 1'b0;
      motorQ <= 2'b00;
      drvQ   <= 1'b0;
    end else begin
      trkQ   <= trackZero;
      dmaQ   <= dmaReq;
      irqQ   <= irqPending;
      motorQ <= motorEn;
      drvQ   <= driveSel0;
    end
  end

  // domain also cleared by the software reset
  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      stepLatch <= 1'b0;
      tglRd     <= 1'b0;
      tglWr     <= 1'b0;
      wgQ       <= 1'b0;
    end else if (strb.clrSoft) begin
      stepLatch <= 1'b0;
      tglRd     <= 1'b0;
      tglWr     <= 1'b0;
      wgQ       <= 1'b0;
    end else begin
      wgQ   <= writeGate;
      tglRd <= tglRd ^ strb.rdFlip;
      tglWr <= tglWr ^ strb.wrFlip;
      if (strb.stepSet)      stepLatch <= 1'b1;
      else if (strb.stepClr) stepLatch <= 1'b0;
    end
  end

  assign statA = {irqQ, dmaQ, stepLatch, trkQ, 4'b0000};
  assign statB = {2'b11, drvQ, tglWr, tglRd, wgQ, motorQ};

  always_comb begin
    if (strb.selA)      busData = statA;
    else if (strb.selB) busData = statB;
    else                busData = '0;
  end
endmodule

// File: rtl/disk_status_regs.sv
module disk_status_regs
  import disk_status_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              hwRstN,
  input  logic              swReset,
  input  logic              ps2Mode,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              dirRead,
  input  logic              trackZero,
  input  logic              stepOut,
  input  logic              dmaReq,
  input  logic              irqPending,
  input  logic [1:0]        motorEn,
  input  logic              writeGate,
  input  logic              driveSel0,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  output logic [7:0]        busData,
  output logic              busOe
);
  strobe_t           strb;
  logic [DATA_W-1:0] statA;
  logic [DATA_W-1:0] statB;

  disk_status_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .hwRstN(hwRstN), .swReset(swReset), .ps2Mode(ps2Mode),
    .hostRd(hostRd), .hostAddr(hostAddr), .dirRead(dirRead), .stepOut(stepOut),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .strb(strb), .busOe(busOe)
  );

  disk_status_dpath uDpath (
    .clk(clk), .hwRstN(hwRstN), .strb(strb), .trackZero(trackZero),
    .dmaReq(dmaReq), .irqPending(irqPending), .motorEn(motorEn),
    .writeGate(writeGate), .driveSel0(driveSel0), .statA(statA),
    .statB(statB), .busData(busData)
  );
endmodule

// File: rtl/disk_status_check.sv
module disk_status_check #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              hwRstN,
  input logic              swReset,
  input logic              ps2Mode,
  input logic              hostAddr1,
  input logic              stepOut,
  input logic              dirRead,
  input logic [1:0]        motorEn,
  input logic              driveSel0,
  input logic [7:0]        statA,
  input logic [7:0]        statB,
  input logic              selB,
  input logic              busOe,
  input logic [7:0]        busData
);
  a_r3_step_set: assert property (@(posedge clk) disable iff (!hwRstN || swReset)
    (stepOut && !$past(stepOut)) |=> statA[5]);

  a_r4_step_clear: assert property (@(posedge clk) disable iff (!hwRstN || swReset)
    (dirRead && !(stepOut && !$past(stepOut))) |=> !statA[5]);

  a_r7_keep_on_soft: assert property (@(posedge clk) disable iff (!hwRstN)
    swReset |=> (statB[1:0] == $past(motorEn)) && (statB[5] == $past(driveSel0)));

  a_r10_soft_clear: assert property (@(posedge clk) disable iff (!hwRstN)
    swReset |=> (statB[4:2] == 3'b000) && !statA[5]);

  a_r6_fixed_ones: assert property (@(posedge clk) disable iff (!hwRstN)
    selB |-> (busData[7:6] == 2'b11));

  a_r12_at_mode_quiet: assert property (@(posedge clk) disable iff (!hwRstN)
    (!ps2Mode && hostAddr1) |-> !busOe);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!hwRstN)
    !busOe |-> (busData == 8'h00));
endmodule

bind disk_status_regs disk_status_check #(.ADDR_W(ADDR_W)) uCheck (
  .clk(clk), .hwRstN(hwRstN), .swReset(swReset), .ps2Mode(ps2Mode),
  .hostAddr1(hostAddr == ADDR_W'(1)), .stepOut(stepOut), .dirRead(dirRead),
  .motorEn(motorEn), .driveSel0(driveSel0), .statA(statA), .statB(statB),
  .selB(strb.selB), .busOe(busOe), .busData(busData)
);

// File: tb/disk_status_regs_test.sv
`timescale 1ns/1ps
module disk_status_regs_test;
  localparam int ADDR_W = 3;

  logic clk = 1'b0;
  logic hwRstN, swReset, ps2Mode, hostRd, dirRead;
  logic [ADDR_W-1:0] hostAddr;
  logic trackZero, stepOut, dmaReq, irqPending, writeGate, driveSel0;
  logic rdStrobe, wrStrobe;
  logic [1:0] motorEn;
  logic [7:0] busData;
  logic busOe;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  disk_status_regs #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .hwRstN(hwRstN), .swReset(swReset), .ps2Mode(ps2Mode),
    .hostRd(hostRd), .hostAddr(hostAddr), .dirRead(dirRead),
    .trackZero(trackZero), .stepOut(stepOut), .dmaReq(dmaReq),
    .irqPending(irqPending), .motorEn(motorEn), .writeGate(writeGate),
    .driveSel0(driveSel0), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .busData(busData), .busOe(busOe)
  );

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input int a, output logic [7:0] d);
    hostRd = 1'b1;
    hostAddr = ADDR_W'(a);
    #1;
    d = busData;
    hostRd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cntR, cntW;
    logic prevR, prevW;
    hwRstN = 0; swReset = 0; ps2Mode = 1; hostRd = 0; hostAddr = '0; dirRead = 0;
    trackZero = 0; stepOut = 0; dmaReq = 0; irqPending = 0; writeGate = 0;
    driveSel0 = 0; motorEn = 2'b00; rdStrobe = 0; wrStrobe = 0;
    wait_cycles(3);
    read_reg(0, d); check("R1 reg0 in reset", d, 8'h00);
    read_reg(1, d); check("R1 reg1 in reset", d, 8'hC0);
    hwRstN = 1;
    wait_cycles(2);
    read_reg(0, d); check("R1 reg0 after reset", d, 8'h00);
    read_reg(1, d); check("R1 reg1 after reset", d, 8'hC0);

    // R2 R6: sweep of all level input combinations
    for (int v = 0; v < 128; v++) begin
      logic [6:0] b;
      b = 7'(v);
      trackZero = b[0]; dmaReq = b[1]; irqPending = b[2];
      motorEn = b[4:3]; writeGate = b[5]; driveSel0 = b[6];
      wait_cycles(1);
      read_reg(0, d); check("R2 level map", d, {b[2], b[1], 1'b0, b[0], 4'b0000});
      read_reg(1, d); check("R6 level map", d, {2'b11, b[6], 2'b00, b[5], b[4:3]});
    end
    trackZero = 0; dmaReq = 0; irqPending = 0; motorEn = 0; writeGate = 0; driveSel0 = 0;
    wait_cycles(1);

    // R11 R12: decode sweep
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < (1 << ADDR_W); a++) begin
        for (int r = 0; r < 2; r++) begin
          logic expOe;
          ps2Mode = m[0]; hostRd = r[0]; hostAddr = ADDR_W'(a);
          #1;
          expOe = r[0] && (a == 0 || (a == 1 && m[0]));
          if (a == 1 && m == 0) check("R12 at mode oe", {7'b0, busOe}, 8'h00);
          else check("R11 oe decode", {7'b0, busOe}, {7'b0, expOe});
          if (!expOe) check("R11 idle data", busData, 8'h00);
          hostRd = 0;
          wait_cycles(1);
        end
      end
    end
    ps2Mode = 1;

    // R8 R9: toggle parity sweep
    cntR = 0; cntW = 0; prevR = 0; prevW = 0;
    for (int p = 0; p < 16; p++) begin
      logic [3:0] pb;
      pb = 4'(p);
      for (int k = 0; k < 4; k++) begin
        rdStrobe = pb[k];
        wrStrobe = pb[3-k];
        if (prevR && !pb[k]) cntR++;
        if (prevW && !pb[3-k]) cntW++;
        prevR = pb[k]; prevW = pb[3-k];
        wait_cycles(3);
      end
      read_reg(1, d);
      check("R8 R9 toggle parity", d[4:3], {cntW[0], cntR[0]});
    end
    rdStrobe = 0; wrStrobe = 0;
    wait_cycles(4);

    // R3 R4: step latch
    swReset = 1; wait_cycles(1); swReset = 0; wait_cycles(1);
    stepOut = 1; wait_cycles(1);
    read_reg(0, d); check("R3 step set", d[5], 1'b1);
    wait_cycles(2);
    read_reg(0, d); check("R3 step held high", d[5], 1'b1);
    stepOut = 0; wait_cycles(2);
    read_reg(0, d); check("R3 step after fall", d[5], 1'b1);
    read_reg(0, d); check("R3 read keeps step", d[5], 1'b1);
    dirRead = 1; wait_cycles(1); dirRead = 0;
    read_reg(0, d); check("R4 dir read clears", d[5], 1'b0);
    stepOut = 1; dirRead = 1; wait_cycles(1); dirRead = 0; stepOut = 0;
    read_reg(0, d); check("R4 set wins", d[5], 1'b1);
    dirRead = 1; wait_cycles(1); dirRead = 0;
    read_reg(0, d); check("R4 clear again", d[5], 1'b0);

    // R5 R7 R10: software reset
    stepOut = 1; wait_cycles(1); stepOut = 0;
    rdStrobe = 1; wait_cycles(4); rdStrobe = 0; wait_cycles(4);
    motorEn = 2'b11; driveSel0 = 1; writeGate = 1; wait_cycles(1);
    read_reg(1, d); check("R6 before soft reset", d, 8'hEF);
    read_reg(0, d); check("R3 before soft reset", d[5], 1'b1);
    swReset = 1; wait_cycles(1);
    read_reg(1, d); check("R10 soft reset reg1", d, 8'hE3);
    read_reg(0, d); check("R5 soft reset step", d[5], 1'b0);
    motorEn = 2'b01; wait_cycles(1);
    read_reg(1, d); check("R7 motor tracks in soft reset", d, 8'hE1);
    swReset = 0; wait_cycles(1);
    read_reg(1, d); check("R10 wgate back after soft reset", d, 8'hE5);

    // R1 R5 R10: hardware reset
    stepOut = 1; wait_cycles(1); stepOut = 0;
    rdStrobe = 1; wait_cycles(4); rdStrobe = 0; wait_cycles(4);
    hwRstN = 0; #1;
    read_reg(1, d); check("R10 hw reset reg1", d, 8'hC0);
    read_reg(0, d); check("R5 hw reset reg0", d, 8'h00);
    wait_cycles(1);
    hwRstN = 1; wait_cycles(2);
    read_reg(1, d); check("R6 after hw reset", d, 8'hE5);
    read_reg(0, d); check("R5 step stays clear", d[5], 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule